// File: doc/BRIEF.md
# Serial Converter Control Sequencer

This block is the digital side of an 8-bit multi-channel converter that a host drives over a three-wire serial port: an active-low select, a host-driven shift clock and a serial address line. The logic runs on an internal system clock. It brings the port signals into that domain through two-flop synchronizers. It qualifies the select so that a brief glitch is rejected. During each transfer it takes in a 4-bit channel code while it sends the result of the previous conversion back, MSB first.

After the eighth shift-clock falling edge the block releases the data line. It holds the sample enable for a fixed extra window, pulses a convert strobe and then times a fixed-length conversion. At the end it latches the value on a stub result input and raises the end-of-conversion flag. The analog front end and the approximation core are outside the block. Only the channel select, sample enable, convert strobe and busy flag go out to them.

Top module: `sadc_ctrl`

## Requirements
- R1: After reset `dout_oe`, `sample_en` and `conv_busy` are 0, `eoc` is 1 and the stored result is 0x00.
- R2: While select is not accepted (`cs_n` high), `dout_oe` is 0. Shift-clock and address activity neither alters the stored result, nor starts sampling or conversion.
- R3: A low on `cs_n` is accepted only once its synchronized copy has been low at two consecutive system-clock rising edges and a system-clock falling edge has followed. A low pulse that lasts one system-clock period is never accepted.
- R4: Within 8 system clocks of an accepted select, `dout_oe` is 1 and `dout` carries bit 7 of the stored result.
- R5: The first four shift-clock rising edges capture `addr_in`, MSB first. From the fourth falling edge `mux_sel` holds the code. `selftest` is 1 exactly when the code is 11 or greater, and codes 0 to 10 pick analog inputs.
- R6: Each of shift-clock falling edges 1 to 7 moves the next lower result bit (bit 6 down to bit 0) onto `dout`.
- R7: `sample_en` is 1 from the fourth falling edge until the end of an extra window of 12 system clocks that starts at the eighth falling edge. A one-cycle `conv_start` follows, and `conv_busy` is then 1 for 20 system clocks. Sampling and converting never overlap.
- R8: The eighth falling edge drives `eoc` low and `dout_oe` low. When the conversion ends, `eoc` returns high and `conv_data` is stored as the new result.
- R9: A newly accepted select during the sampling window or the conversion aborts it. `eoc` goes high and the previously stored result is kept and offered on `dout`.
- R10: With `cs_n` held low across conversions, the block re-enables `dout` with the new result's MSB when a conversion ends, and it accepts the next transfer without a new select edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select from the host |
| io_clk | input | 1 | Host shift clock |
| addr_in | input | 1 | Serial channel code, MSB first |
| conv_data | input | 8 | Result from the conversion stub |
| dout | output | 1 | Serial result bit |
| dout_oe | output | 1 | Drive enable for `dout`; 0 means high impedance |
| mux_sel | output | 4 | Latched channel code |
| selftest | output | 1 | Code selects the self-test source |
| sample_en | output | 1 | Sample-and-hold tracking enable |
| conv_start | output | 1 | One-cycle strobe that starts conversion |
| conv_busy | output | 1 | Conversion in progress |
| eoc | output | 1 | End-of-conversion flag, low while busy |

## Verification
On every cycle the assertions check the following: the sampling window and the conversion never overlap, a convert strobe is always followed by busy, `eoc` falls only on a completed eighth edge, the data line is never driven while `eoc` is low, and an accepted select always leaves the sequencer idle with `eoc` high. What the result bits carry, the address capture order, glitch rejection and the fact that an abort keeps the old result can only be seen through the bench's transfers. Those transfers compare each word read back with the value loaded one conversion earlier.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 8;
  localparam int N_ANALOG = 11;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_SAMP = 2'd1,
    SQ_CONV = 2'd2
  } seq_state_t;

  // a code at or above the analog count routes to the self-test source
  function automatic logic is_selftest(input logic [ADDR_W-1:0] code);
    return code >= ADDR_W'(N_ANALOG);
  endfunction

  // serial capture, new bit enters at the LSB
  function automatic logic [ADDR_W-1:0] shift_code(input logic [ADDR_W-1:0] cur,
                                                   input logic bit_in);
    return {cur[ADDR_W-2:0], bit_in};
  endfunction

  // serial launch, next lower bit moves to the MSB
  function automatic logic [DATA_W-1:0] shift_word(input logic [DATA_W-1:0] cur);
    return {cur[DATA_W-2:0], 1'b0};
  endfunction
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sadc_csqual.sv
module sadc_csqual #(
  parameter int QUAL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_low,
  output logic cs_act,
  output logic cs_start
);
  localparam int QW = $clog2(QUAL + 1);

  logic [QW-1:0] low_cnt;
  logic          cs_qual;
  logic          cs_act_d;

  // consecutive rising edges that saw the synchronized select low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (!cs_low) low_cnt <= '0;
    else if (low_cnt != QW'(QUAL)) low_cnt <= low_cnt + 1'b1;
  end

  assign cs_qual = (low_cnt == QW'(QUAL));

  // acceptance waits for the following falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) cs_act <= 1'b0;
    else cs_act <= cs_qual;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_act_d <= 1'b0;
    else cs_act_d <= cs_act;
  end

  assign cs_start = cs_act & ~cs_act_d;
endmodule

// File: rtl/sadc_serial.sv
module sadc_serial
  import sadc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              cs_start,
  input  logic              reload,
  input  logic              io_s,
  input  logic              addr_s,
  input  logic [DATA_W-1:0] result,
  output logic              dout,
  output logic              dout_oe,
  output logic [ADDR_W-1:0] mux_sel,
  output logic              xfer_samp,
  output logic              xfer_done
);
  localparam int CW = $clog2(DATA_W + 1);

  logic              io_d;
  logic              xfer_en;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] code_sh;
  logic [DATA_W-1:0] tx;
  logic              io_rise, io_fall, live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) io_d <= 1'b0;
    else io_d <= io_s;
  end

  assign live      = cs_act & xfer_en;
  assign io_rise   = live &  io_s & ~io_d;
  assign io_fall   = live & ~io_s &  io_d;
  assign xfer_done = io_fall & (cnt == CW'(DATA_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_en <= 1'b0;
      cnt     <= '0;
      code_sh <= '0;
      tx      <= '0;
      mux_sel <= '0;
    end else if (cs_start || (reload && cs_act)) begin
      xfer_en <= 1'b1;
      cnt     <= '0;
      tx      <= result;
    end else if (!cs_act) begin
      xfer_en <= 1'b0;
    end else begin
      if (io_rise && cnt < CW'(ADDR_W))
        code_sh <= shift_code(code_sh, addr_s);
      if (io_fall) begin
        cnt <= cnt + 1'b1;
        tx  <= shift_word(tx);
        if (cnt == CW'(ADDR_W - 1)) mux_sel <= code_sh;
        if (xfer_done) xfer_en <= 1'b0;
      end
    end
  end

  assign dout      = tx[DATA_W-1];
  assign dout_oe   = live;
  assign xfer_samp = live & (cnt >= CW'(ADDR_W));
endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
  import sadc_pkg::*;
#(
  parameter int SAMP_CLKS = 12,
  parameter int CONV_CLKS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              xfer_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              samp_win,
  output logic              conv_start,
  output logic              conv_busy,
  output logic              eoc,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  localparam int TMAX = (SAMP_CLKS > CONV_CLKS) ? SAMP_CLKS : CONV_CLKS;
  localparam int TW   = $clog2(TMAX + 1);

  seq_state_t    st;
  logic [TW-1:0] tmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SQ_IDLE;
      tmr    <= '0;
      eoc    <= 1'b1;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        st  <= SQ_IDLE;
        eoc <= 1'b1;
      end else begin
        unique case (st)
          SQ_IDLE: if (xfer_done) begin
            st  <= SQ_SAMP;
            tmr <= TW'(SAMP_CLKS - 1);
            eoc <= 1'b0;
          end
          SQ_SAMP: if (tmr == '0) begin
            st  <= SQ_CONV;
            tmr <= TW'(CONV_CLKS - 1);
          end else tmr <= tmr - 1'b1;
          SQ_CONV: if (tmr == '0) begin
            st     <= SQ_IDLE;
            eoc    <= 1'b1;
            done   <= 1'b1;
            result <= conv_data;
          end else tmr <= tmr - 1'b1;
          default: st <= SQ_IDLE;
        endcase
      end
    end
  end

  assign samp_win   = (st == SQ_SAMP);
  assign conv_busy  = (st == SQ_CONV);
  assign conv_start = samp_win & (tmr == '0) & ~abort;
endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
  import sadc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL        = 2,
  parameter int SAMP_CLKS   = 12,
  parameter int CONV_CLKS   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              io_clk,
  input  logic              addr_in,
  input  logic [DATA_W-1:0] conv_data,
  output logic              dout,
  output logic              dout_oe,
  output logic [ADDR_W-1:0] mux_sel,
  output logic              selftest,
  output logic              sample_en,
  output logic              conv_start,
  output logic              conv_busy,
  output logic              eoc
);
  logic [2:0]        port_s;
  logic              cs_act, cs_start, xfer_samp, xfer_done;
  logic              samp_win, done;
  logic [DATA_W-1:0] result;

  sadc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, io_clk, addr_in}), .q(port_s)
  );

  sadc_csqual #(.QUAL(QUAL)) u_qual (
    .clk(clk), .rst_n(rst_n), .cs_low(~port_s[2]),
    .cs_act(cs_act), .cs_start(cs_start)
  );

  sadc_serial u_ser (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_start(cs_start),
    .reload(done), .io_s(port_s[1]), .addr_s(port_s[0]), .result(result),
    .dout(dout), .dout_oe(dout_oe), .mux_sel(mux_sel),
    .xfer_samp(xfer_samp), .xfer_done(xfer_done)
  );

  sadc_seq #(.SAMP_CLKS(SAMP_CLKS), .CONV_CLKS(CONV_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .abort(cs_start), .xfer_done(xfer_done),
    .conv_data(conv_data), .samp_win(samp_win), .conv_start(conv_start),
    .conv_busy(conv_busy), .eoc(eoc), .done(done), .result(result)
  );

  assign selftest  = is_selftest(mux_sel);
  assign sample_en = xfer_samp | samp_win;
endmodule

// File: rtl/sadc_ctrl_chk.sv
module sadc_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic dout_oe,
  input logic eoc,
  input logic samp_win,
  input logic conv_busy,
  input logic conv_start,
  input logic xfer_done,
  input logic cs_start
);
  // R7
  win_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({samp_win, conv_busy}));

  // R7
  conv_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> conv_busy);

  // R8
  eoc_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc) |-> $past(xfer_done));

  // R8
  oe_eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> eoc);

  // R7
  busy_eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_win || conv_busy) |-> !eoc);

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_start |=> (eoc && !conv_busy && !samp_win));
endmodule

bind sadc_ctrl sadc_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dout_oe(dout_oe), .eoc(eoc),
  .samp_win(samp_win), .conv_busy(conv_busy), .conv_start(conv_start),
  .xfer_done(xfer_done), .cs_start(cs_start)
);

// File: tb/sadc_ctrl_test.sv
module sadc_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, io_clk = 1'b0, addr_in = 1'b0;
  logic [7:0] conv_data = 8'h00;
  logic       dout, dout_oe, selftest, sample_en, conv_start, conv_busy, eoc;
  logic [3:0] mux_sel;
  int         checks = 0, errors = 0;
  logic [7:0] prev, rd;

  always #4 clk = ~clk;

  sadc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .io_clk(io_clk), .addr_in(addr_in),
    .conv_data(conv_data), .dout(dout), .dout_oe(dout_oe), .mux_sel(mux_sel),
    .selftest(selftest), .sample_en(sample_en), .conv_start(conv_start),
    .conv_busy(conv_busy), .eoc(eoc)
  );

  // {channel code, value the stub returns for that conversion}
  localparam logic [11:0] VEC [6] = '{
    {4'd5,  8'hA5}, {4'd11, 8'h3C}, {4'd0,  8'hFF},
    {4'd10, 8'h01}, {4'd15, 8'h80}, {4'd12, 8'h5A}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // full transfer; returns the word read out, checks code and sampling
  task automatic xfer(input logic [3:0] code, output logic [7:0] word);
    word[7] = dout;
    for (int i = 0; i < 8; i++) begin
      if (i < 4) addr_in = code[3-i];
      wclk(6);
      io_clk = 1'b1;
      wclk(6);
      io_clk = 1'b0;
      wclk(6);
      if (i < 7) word[6-i] = dout;
      if (i == 2) check("R7 no sampling before 4th edge", sample_en, 0);
      if (i == 3) begin
        check("R5 mux_sel", mux_sel, code);
        check("R5 selftest", selftest, (code >= 4'd11) ? 1 : 0);
        check("R7 sampling after 4th edge", sample_en, 1);
      end
    end
  endtask

  task automatic finish_conv();
    check("R8 eoc low after 8th edge", eoc, 0);
    check("R8 dout released", dout_oe, 0);
    check("R7 extra window sampling", sample_en, 1);
    wclk(14);
    check("R7 converting", conv_busy, 1);
    check("R7 sampling off during conversion", sample_en, 0);
    wclk(20);
    check("R8 eoc high at end", eoc, 1);
    check("R8 busy cleared", conv_busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wclk(3);
    // R1 reset state
    check("R1 oe", dout_oe, 0);
    check("R1 eoc", eoc, 1);
    check("R1 sample_en", sample_en, 0);
    check("R1 conv_busy", conv_busy, 0);
    rst_n = 1'b1;
    wclk(3);

    // R3 one-period glitch is rejected
    cs_n = 1'b0;
    wclk(1);
    cs_n = 1'b1;
    wclk(10);
    check("R3 glitch not accepted", dout_oe, 0);

    // R4 accepted select presents MSB of reset result
    cs_n = 1'b0;
    wclk(8);
    check("R4 oe after accept", dout_oe, 1);
    check("R4 MSB of result", dout, 0);

    // R6 R10 table, select held low for all conversions
    prev = 8'h00;
    for (int v = 0; v < 6; v++) begin
      conv_data = VEC[v][7:0];
      xfer(VEC[v][11:8], rd);
      check("R6 word read out", rd, prev);
      finish_conv();
      prev = VEC[v][7:0];
      wclk(2);
      check("R10 oe back with select held", dout_oe, 1);
      check("R10 new MSB", dout, prev[7]);
    end

    // R2 select high: shift activity is ignored
    cs_n = 1'b1;
    wclk(8);
    conv_data = 8'h11;
    for (int i = 0; i < 8; i++) begin
      addr_in = i[0];
      io_clk = 1'b1;
      wclk(6);
      io_clk = 1'b0;
      wclk(6);
      check("R2 oe stays low", dout_oe, 0);
      check("R2 no conversion", eoc, 1);
    end
    cs_n = 1'b0;
    wclk(8);
    xfer(4'd3, rd);
    check("R2 result untouched", rd, prev);

    // R9 select taken high and re-accepted mid-sequence aborts
    cs_n = 1'b1;
    wclk(4);
    cs_n = 1'b0;
    wclk(8);
    check("R9 eoc high after abort", eoc, 1);
    check("R9 no conversion after abort", conv_busy, 0);
    check("R9 old MSB offered", dout, prev[7]);
    conv_data = 8'h66;
    xfer(4'd7, rd);
    check("R9 old result kept", rd, prev);
    finish_conv();
    wclk(2);
    xfer(4'd1, rd);
    check("R9 next conversion stored", rd, 8'h66);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule